// File: doc/BRIEF.md
# Peripheral DMA Channel Engine

This block is a single DMA channel that copies data between memory and the data port of a peripheral. Software sets a source address, a destination address, a beat width, a burst type and a burst count over a 32-bit register port, then sets the channel enable bit. The engine moves the data in bursts. Each burst waits for the peripheral's request line. Each beat is a read from the source followed by a write to the destination over a simple memory master port.

Either side can be held at a fixed address, which is how the peripheral's data port is addressed. The two address registers are the live counters, so software can read them at any time to see how far the transfer has gone. The channel stops when software pauses it, when software clears its enable bit, when it finishes, or when the memory reports an error. Completion and error each write a status code that can raise the interrupt output.

Top module: `pdma_chan`

## Requirements
- R1: Register map, all 32 bits wide and zero after reset. Offsets are 0x00 global control, 0x10 control A, 0x14 control B, 0x18 source address and 0x1C destination address.
  - Global control: bit 31 is the global enable.
  - Control A: bit 31 channel enable, bit 30 pause, bits 28:24 request ID, bits 23:20 burst type, bits 15:0 burst count.
  - Control B: bits 27:26 width code, bit 25 fixed source, bit 24 fixed destination, bit 20 error interrupt enable, bit 19 completion interrupt enable, bits 18:16 status.
  - Every field reads back as written, and every other bit reads as zero.
- R2: Burst type 0xF gives 16 beats per burst, 0xD gives 8 beats and 0xB gives 4 beats. Every other value gives 1 beat.
- R3: A transfer moves (count+1) × beats × width bytes. Each beat is one read at the source address, then one write of the same data at the destination address, with `mem_size` equal to the width code. Width code 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes.
- R4: After each accepted write, the source and destination address registers each advance by the beat width. A side whose fixed bit is set keeps its address. The registers always hold the live position.
- R5: A burst starts only after `per_req` is seen high. `per_ack` pulses high for exactly one cycle when the last write of each burst is accepted.
- R6: While the pause bit is set, or the global enable is low, no new beat starts. Clearing the hold resumes the transfer from the current addresses.
- R7: Writing 0 to the channel enable aborts the channel. `mem_req` is low from the cycle after that write onward, and the status is left unchanged.
- R8: When the last write of the last burst is accepted, the status becomes 3'b101 and the channel enable bit reads 0.
- R9: When `mem_err` is answered to a request, that access is dropped, the status becomes 3'b001, the channel enable clears, and no further request is made.
- R10: `irq` is high exactly while either of these holds:
  - the status is 3'b101 and the completion interrupt is enabled, or
  - the status is 3'b001 and the error interrupt is enabled.
  Software writes the status field directly, and writing 0 to it clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledge or error |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_size | output | 2 | Beat size code: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes |
| mem_wdata | output | 32 | Write data (low bytes significant) |
| mem_ack | input | 1 | Access accepted in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Access failed in this cycle |
| per_req | input | 1 | Peripheral ready for a burst |
| per_ack | output | 1 | One-cycle pulse at the end of each burst |
| irq | output | 1 | Interrupt |

## Verification
The bench attacks the corners listed below, and each describes what a faulty design would show.
- **Burst decode.** The vectors cover every burst-type decode, including an undefined code. A wrong decode changes the ratio of beats to `per_ack` pulses.
- **Fixed sides.** Either side is held fixed in some vectors. A design that steps a fixed address, or forgets to step a live one, leaves a wrong final address or scrambles the copied bytes.
- **Holds.** The bench holds the engine with `per_req` low, with pause set before start, with the global enable low, and with a pause in the middle of a burst. A design that checks the hold only at burst boundaries keeps writing beats after the pause lands.
- **Abort and error.** Both endings are checked for silence on `mem_req` afterwards. The error case also checks that the failed destination address is left in place, and that the interrupt follows the status code and its enable bits.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;

    localparam int TC_W = 16;

    // register byte offsets
    localparam int OFS_GLOB = 'h00;
    localparam int OFS_CA   = 'h10;
    localparam int OFS_CB   = 'h14;
    localparam int OFS_SA   = 'h18;
    localparam int OFS_DA   = 'h1C;

    localparam logic [3:0] BT_X16 = 4'hF;
    localparam logic [3:0] BT_X8  = 4'hD;
    localparam logic [3:0] BT_X4  = 4'hB;

    localparam logic [2:0] STAT_NONE = 3'b000;
    localparam logic [2:0] STAT_DONE = 3'b101;
    localparam logic [2:0] STAT_FAIL = 3'b001;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_WAITREQ,
        XS_GAP,
        XS_READ,
        XS_WRITE
    } xfer_state_e;

    typedef struct packed {
        logic            en;
        logic            pause;
        logic [4:0]      rid;
        logic [3:0]      btype;
        logic [TC_W-1:0] tc;
    } ctrl_a_t;

    typedef struct packed {
        logic [1:0] wcode;
        logic       fix_src;
        logic       fix_dst;
        logic       err_ie;
        logic       done_ie;
        logic [2:0] status;
    } ctrl_b_t;

    // what the transfer engine needs from the register file
    typedef struct packed {
        logic            en;
        logic            pause;
        logic            glob;
        logic [3:0]      btype;
        logic [TC_W-1:0] tc;
        logic [1:0]      wcode;
    } xfer_cfg_t;

    function automatic logic [4:0] burst_beats(input logic [3:0] bt);
        case (bt)
            BT_X16:  return 5'd16;
            BT_X8:   return 5'd8;
            BT_X4:   return 5'd4;
            default: return 5'd1;
        endcase
    endfunction

    function automatic logic [2:0] beat_bytes(input logic [1:0] wc);
        case (wc)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] size_code(input logic [1:0] wc);
        return (wc == 2'd3) ? 2'd2 : wc;
    endfunction

endpackage

// File: rtl/pdma_regs.sv
`timescale 1ns/1ps
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              glob_en,
    output ctrl_a_t           ca,
    output ctrl_b_t           cb,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    input  logic              step,
    input  logic              fin_ok,
    input  logic              fin_err,
    output logic              irq
);

    localparam logic [REG_AW-1:0] A_GLOB = REG_AW'(OFS_GLOB);
    localparam logic [REG_AW-1:0] A_CA   = REG_AW'(OFS_CA);
    localparam logic [REG_AW-1:0] A_CB   = REG_AW'(OFS_CB);
    localparam logic [REG_AW-1:0] A_SA   = REG_AW'(OFS_SA);
    localparam logic [REG_AW-1:0] A_DA   = REG_AW'(OFS_DA);

    logic    glob_q;
    ctrl_a_t ca_q;
    ctrl_b_t cb_q;

    logic hit_glob, hit_ca, hit_cb, hit_sa, hit_da;
    assign hit_glob = reg_wr && (reg_addr == A_GLOB);
    assign hit_ca   = reg_wr && (reg_addr == A_CA);
    assign hit_cb   = reg_wr && (reg_addr == A_CB);
    assign hit_sa   = reg_wr && (reg_addr == A_SA);
    assign hit_da   = reg_wr && (reg_addr == A_DA);

    wire unused_wbits = ^{reg_wdata[30:0] & 32'h2000_0000, reg_wdata[29],
                          reg_wdata[19:16], reg_wdata[31:28], reg_wdata[23:21],
                          reg_wdata[15:0]};

    // control registers; completion and error override a same-cycle write
    always_ff @(posedge clk) begin
        if (rst) begin
            glob_q <= 1'b0;
            ca_q   <= '0;
            cb_q   <= '0;
        end else begin
            if (hit_glob) glob_q <= reg_wdata[31];
            if (hit_ca) begin
                ca_q.en    <= reg_wdata[31];
                ca_q.pause <= reg_wdata[30];
                ca_q.rid   <= reg_wdata[28:24];
                ca_q.btype <= reg_wdata[23:20];
                ca_q.tc    <= reg_wdata[TC_W-1:0];
            end
            if (hit_cb) begin
                cb_q.wcode   <= reg_wdata[27:26];
                cb_q.fix_src <= reg_wdata[25];
                cb_q.fix_dst <= reg_wdata[24];
                cb_q.err_ie  <= reg_wdata[20];
                cb_q.done_ie <= reg_wdata[19];
                cb_q.status  <= reg_wdata[18:16];
            end
            if (fin_ok) begin
                ca_q.en     <= 1'b0;
                cb_q.status <= STAT_DONE;
            end
            if (fin_err) begin
                ca_q.en     <= 1'b0;
                cb_q.status <= STAT_FAIL;
            end
        end
    end

    // live address counters, one per side
    logic [1:0][ADDR_W-1:0] addr_w;
    logic [1:0]             hit_addr;
    logic [1:0]             fixed;
    assign hit_addr = {hit_da, hit_sa};
    assign fixed    = {cb_q.fix_dst, cb_q.fix_src};

    for (genvar g = 0; g < 2; g++) begin : g_side
        logic [ADDR_W-1:0] a_q;
        always_ff @(posedge clk) begin
            if (rst)
                a_q <= '0;
            else if (hit_addr[g])
                a_q <= reg_wdata[ADDR_W-1:0];
            else if (step && !fixed[g])
                a_q <= a_q + ADDR_W'(beat_bytes(cb_q.wcode));
        end
        assign addr_w[g] = a_q;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_GLOB: reg_rdata[31] = glob_q;
            A_CA:   reg_rdata = {ca_q.en, ca_q.pause, 1'b0, ca_q.rid, ca_q.btype,
                                 4'b0, ca_q.tc};
            A_CB:   reg_rdata = {4'b0, cb_q.wcode, cb_q.fix_src, cb_q.fix_dst, 3'b0,
                                 cb_q.err_ie, cb_q.done_ie, cb_q.status, 16'b0};
            A_SA:   reg_rdata = 32'(addr_w[0]);
            A_DA:   reg_rdata = 32'(addr_w[1]);
            default: reg_rdata = '0;
        endcase
    end

    assign glob_en  = glob_q;
    assign ca       = ca_q;
    assign cb       = cb_q;
    assign src_addr = addr_w[0];
    assign dst_addr = addr_w[1];
    assign irq = ((cb_q.status == STAT_DONE) && cb_q.done_ie) ||
                 ((cb_q.status == STAT_FAIL) && cb_q.err_ie);

    // R8
    done_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
        fin_ok |=> (!ca_q.en && cb_q.status == STAT_DONE));
    // R9
    err_stops_chk: assert property (@(posedge clk) disable iff (rst)
        fin_err |=> (!ca_q.en && cb_q.status == STAT_FAIL));
    // R4
    src_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !cb_q.fix_src && !hit_sa) |=>
        (addr_w[0] == $past(addr_w[0]) + ADDR_W'($past(beat_bytes(cb_q.wcode)))));
    // R4
    dst_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (step && cb_q.fix_dst && !hit_da) |=> $stable(addr_w[1]));
    // R10
    irq_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        (fin_ok && cb_q.done_ie && !hit_cb) |=> irq);

endmodule

// File: rtl/pdma_xfer.sv
`timescale 1ns/1ps
module pdma_xfer
    import pdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_cfg_t         cfg,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              per_req,
    output logic              per_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    output logic              step,
    output logic              fin_ok,
    output logic              fin_err
);

    xfer_state_e     st_q, st_d;
    logic [4:0]      beat_q;
    logic [TC_W-1:0] burst_q;
    logic [31:0]     data_q;

    logic live, hold, acc_ok, acc_err, last_beat, last_burst;
    logic [4:0] beat_reload;

    assign live        = cfg.en;
    assign hold        = cfg.pause || !cfg.glob;
    assign beat_reload = burst_beats(cfg.btype) - 5'd1;
    assign last_beat   = (beat_q == '0);
    assign last_burst  = (burst_q == '0);

    assign mem_req   = live && ((st_q == XS_READ) || (st_q == XS_WRITE));
    assign mem_we    = (st_q == XS_WRITE);
    assign mem_addr  = mem_we ? dst_addr : src_addr;
    assign mem_size  = size_code(cfg.wcode);
    assign mem_wdata = data_q;

    assign acc_err = mem_req && mem_err;
    assign acc_ok  = mem_req && mem_ack && !mem_err;
    assign step    = acc_ok && mem_we;
    assign per_ack = step && last_beat;
    assign fin_ok  = per_ack && last_burst;
    assign fin_err = acc_err;

    always_comb begin
        st_d = st_q;
        case (st_q)
            XS_IDLE:    st_d = XS_WAITREQ;
            XS_WAITREQ: if (!hold && per_req) st_d = XS_READ;
            XS_GAP:     if (!hold) st_d = XS_READ;
            XS_READ: begin
                if (acc_err)     st_d = XS_IDLE;
                else if (acc_ok) st_d = XS_WRITE;
            end
            XS_WRITE: begin
                if (acc_err)
                    st_d = XS_IDLE;
                else if (acc_ok)
                    st_d = !last_beat ? XS_GAP : (last_burst ? XS_IDLE : XS_WAITREQ);
            end
            default: st_d = XS_IDLE;
        endcase
        if (!live) st_d = XS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= XS_IDLE;
            beat_q  <= '0;
            burst_q <= '0;
            data_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == XS_IDLE && live) begin
                beat_q  <= beat_reload;
                burst_q <= cfg.tc;
            end
            if (acc_ok && !mem_we) data_q <= mem_rdata;
            if (step) begin
                if (last_beat) begin
                    beat_q  <= beat_reload;
                    burst_q <= burst_q - 1'b1;
                end else begin
                    beat_q <= beat_q - 1'b1;
                end
            end
        end
    end

    // R5
    per_ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        per_ack |=> !per_ack);
    // R5
    wait_for_req_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == XS_WAITREQ && !per_req) |=> !mem_req);
    // R6
    pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == XS_GAP && hold) |=> !mem_req);
    // R3
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !mem_err) |=> (!mem_req || $stable(mem_addr)));

endmodule

// File: rtl/pdma_chan.sv
`timescale 1ns/1ps
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_err,
    input  logic              per_req,
    output logic              per_ack,
    output logic              irq
);

    logic              glob_en, step, fin_ok, fin_err;
    ctrl_a_t           ca;
    ctrl_b_t           cb;
    logic [ADDR_W-1:0] src_addr, dst_addr;
    xfer_cfg_t         cfg;

    pdma_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .glob_en(glob_en), .ca(ca), .cb(cb),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .step(step), .fin_ok(fin_ok), .fin_err(fin_err), .irq(irq)
    );

    assign cfg.en    = ca.en;
    assign cfg.pause = ca.pause;
    assign cfg.glob  = glob_en;
    assign cfg.btype = ca.btype;
    assign cfg.tc    = ca.tc;
    assign cfg.wcode = cb.wcode;

    wire unused_cfg = ^{ca.rid, cb.fix_src, cb.fix_dst, cb.err_ie, cb.done_ie, cb.status};

    pdma_xfer #(.ADDR_W(ADDR_W)) u_xfer (
        .clk(clk), .rst(rst), .cfg(cfg),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .per_req(per_req), .per_ack(per_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .step(step), .fin_ok(fin_ok), .fin_err(fin_err)
    );

endmodule

// File: tb/pdma_chan_tb.sv
`timescale 1ns/1ps
module pdma_chan_tb;

    localparam logic [7:0] R_GLOB = 8'h00, R_CA = 8'h10, R_CB = 8'h14,
                           R_SA = 8'h18, R_DA = 8'h1C;
    localparam int NVEC = 7;
    // {btype[31:28], width[27:26], fix_src[25], fix_dst[24], 8'h0, count[15:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {4'h0, 2'd0, 2'b00, 8'h0, 16'd3},
        {4'hB, 2'd1, 2'b00, 8'h0, 16'd2},
        {4'hD, 2'd2, 2'b00, 8'h0, 16'd1},
        {4'hF, 2'd2, 2'b00, 8'h0, 16'd3},
        {4'h7, 2'd2, 2'b01, 8'h0, 16'd5},
        {4'hB, 2'd0, 2'b10, 8'h0, 16'd1},
        {4'hD, 2'd1, 2'b00, 8'h0, 16'd0}
    };

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ack, mem_err, per_ack, irq;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        per_req = 1'b0;

    always #4 clk = ~clk;

    pdma_chan u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .per_req(per_req), .per_ack(per_ack), .irq(irq)
    );

    // memory model
    logic [7:0]  mem [512];
    logic        fill_req = 1'b0, err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int          rd_cnt, wr_cnt, pa_cnt, req_cyc;
    int          n_chk = 0, n_fail = 0;

    function automatic logic [7:0] pat(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    assign mem_rdata = {mem[mem_addr[8:0] + 9'd3], mem[mem_addr[8:0] + 9'd2],
                        mem[mem_addr[8:0] + 9'd1], mem[mem_addr[8:0]]};
    assign mem_err = mem_req && err_en && (mem_addr == err_addr);
    assign mem_ack = mem_req && !mem_err;

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 512; i++) mem[i] <= (i < 256) ? pat(i) : 8'h00;
            rd_cnt <= 0; wr_cnt <= 0; pa_cnt <= 0; req_cyc <= 0;
        end else begin
            if (mem_req && mem_ack && mem_we)
                for (int b = 0; b < 4; b++)
                    if (b < nbytes(mem_size)) mem[mem_addr[8:0] + 9'(b)] <= mem_wdata[8*b +: 8];
            if (mem_req && mem_ack && !mem_we) rd_cnt <= rd_cnt + 1;
            if (mem_req && mem_ack && mem_we)  wr_cnt <= wr_cnt + 1;
            if (per_ack) pa_cnt <= pa_cnt + 1;
            if (mem_req) req_cyc <= req_cyc + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic bench_clear();
        @(negedge clk); fill_req = 1'b1;
        @(negedge clk); fill_req = 1'b0;
    endtask

    function automatic logic [31:0] ca_word(input logic en, input logic pz,
                                           input logic [3:0] bt, input logic [15:0] tc);
        return {en, pz, 1'b0, 5'd3, bt, 4'b0, tc};
    endfunction

    task automatic start(input logic [3:0] bt, input logic [1:0] wc, input logic fs,
                         input logic fd, input logic ei, input logic ci,
                         input logic pz, input logic [15:0] tc);
        wr(R_GLOB, 32'h8000_0000);
        wr(R_SA, 32'h0);
        wr(R_DA, 32'h100);
        wr(R_CB, {4'b0, wc, fs, fd, 3'b0, ei, ci, 3'b0, 16'b0});
        wr(R_CA, ca_word(1'b1, pz, bt, tc));
    endtask

    task automatic wait_irq(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (irq) begin ok = 1'b1; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        logic [31:0] d;
        bit ok;
        int a0, r0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        bench_clear();

        // R1 reset state
        rd(R_GLOB, d); chk("R1", "global after reset", d, 0);
        rd(R_CA, d);   chk("R1", "ctrl A after reset", d, 0);
        rd(R_CB, d);   chk("R1", "ctrl B after reset", d, 0);
        rd(R_SA, d);   chk("R1", "src after reset", d, 0);
        chk("R1", "irq/mem_req after reset", {30'b0, irq, mem_req}, 0);

        // R1 field readback, channel left disabled
        wr(R_CA, {1'b0, 1'b1, 1'b0, 5'h15, 4'hA, 4'h0, 16'hBEEF});
        rd(R_CA, d); chk("R1", "ctrl A readback", d, 32'h55A0_BEEF);
        wr(R_CB, 32'hFFFF_FFFF);
        rd(R_CB, d); chk("R1", "ctrl B readback masks reserved", d, 32'h0F1F_0000);
        wr(R_CB, 0); wr(R_CA, 0);

        // table of transfers: R2 R3 R4 R5 R8 R10
        per_req = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            logic [3:0] bt; logic [1:0] wc; logic fs, fd; int tc, beats, wb, nb, n, mism;
            bt = VEC[v][31:28]; wc = VEC[v][27:26]; fs = VEC[v][25]; fd = VEC[v][24];
            tc = int'(VEC[v][15:0]);
            beats = (bt == 4'hF) ? 16 : (bt == 4'hD) ? 8 : (bt == 4'hB) ? 4 : 1;
            wb = (wc == 2'd0) ? 1 : (wc == 2'd1) ? 2 : 4;
            nb = (tc + 1) * beats;
            n  = nb * wb;
            bench_clear();
            start(bt, wc, fs, fd, 1'b0, 1'b1, 1'b0, 16'(tc));
            wait_irq(ok);
            chk("R8", $sformatf("vec%0d irq at completion", v), 32'(ok), 1);
            rd(R_CA, d); chk("R8", $sformatf("vec%0d enable cleared", v), 32'(d[31]), 0);
            rd(R_CB, d); chk("R8", $sformatf("vec%0d status", v), 32'(d[18:16]), 5);
            chk("R3", $sformatf("vec%0d writes", v), wr_cnt, nb);
            chk("R5", $sformatf("vec%0d peripheral acks", v), pa_cnt, tc + 1);
            chk("R2", $sformatf("vec%0d beats per burst", v), wr_cnt / (pa_cnt == 0 ? 1 : pa_cnt), beats);
            rd(R_SA, d); chk("R4", $sformatf("vec%0d src final", v), d, fs ? 0 : n);
            rd(R_DA, d); chk("R4", $sformatf("vec%0d dst final", v), d, fd ? 32'h100 : 32'h100 + n);
            mism = 0;
            if (fd) begin
                for (int j = 0; j < wb; j++) if (mem[256 + j] !== pat(n - wb + j)) mism++;
            end else begin
                for (int k = 0; k < n; k++)
                    if (mem[256 + k] !== (fs ? pat(k % wb) : pat(k))) mism++;
            end
            chk("R3", $sformatf("vec%0d data mismatches", v), mism, 0);
            wr(R_CB, 0);
            chk("R10", $sformatf("vec%0d irq after status clear", v), 32'(irq), 0);
        end

        // R5 burst waits for peripheral request
        bench_clear();
        per_req = 1'b0;
        start(4'hB, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'd1);
        repeat (20) @(negedge clk);
        chk("R5", "no read while per_req low", rd_cnt, 0);
        per_req = 1'b1;
        wait_irq(ok);
        chk("R5", "completes after per_req", wr_cnt, 8);
        wr(R_CB, 0);

        // R6 pause before start, then global enable low
        bench_clear();
        start(4'hB, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd0);
        repeat (20) @(negedge clk);
        chk("R6", "paused channel reads", rd_cnt, 0);
        wr(R_GLOB, 0);
        wr(R_CA, ca_word(1'b1, 1'b0, 4'hB, 16'd0));
        repeat (20) @(negedge clk);
        chk("R6", "global disable holds", rd_cnt, 0);
        wr(R_GLOB, 32'h8000_0000);
        wait_irq(ok);
        chk("R6", "resume completes", wr_cnt, 4);
        rd(R_SA, d); chk("R6", "src after resume", d, 16);
        wr(R_CB, 0);

        // R6 pause in the middle of a burst
        bench_clear();
        start(4'hF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'd0);
        repeat (2) @(negedge clk);
        wr(R_CA, ca_word(1'b1, 1'b1, 4'hF, 16'd0));
        repeat (10) @(negedge clk);
        a0 = wr_cnt;
        chk("R6", "paused mid burst", 32'(a0 > 0 && a0 < 16), 1);
        repeat (20) @(negedge clk);
        chk("R6", "no beats while paused", wr_cnt, a0);
        rd(R_SA, d); chk("R4", "live src shows progress", d, a0);
        wr(R_CA, ca_word(1'b1, 1'b0, 4'hF, 16'd0));
        wait_irq(ok);
        chk("R6", "mid-burst resume finishes", wr_cnt, 16);
        wr(R_CB, 0);

        // R7 abort
        bench_clear();
        start(4'hF, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd3);
        repeat (6) @(negedge clk);
        wr(R_CA, ca_word(1'b0, 1'b0, 4'hF, 16'd3));
        r0 = req_cyc;
        a0 = wr_cnt;
        repeat (20) @(negedge clk);
        chk("R7", "no requests after abort", req_cyc, r0);
        chk("R7", "partial transfer", 32'(a0 > 0 && a0 < 64), 1);
        rd(R_CB, d); chk("R7", "status untouched by abort", 32'(d[18:16]), 0);
        chk("R7", "no irq on abort", 32'(irq), 0);

        // R9 memory error on the fourth write
        bench_clear();
        err_en = 1'b1; err_addr = 32'h10C;
        start(4'hD, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'd1);
        wait_irq(ok);
        chk("R9", "irq on error", 32'(ok), 1);
        rd(R_CB, d); chk("R9", "error status", 32'(d[18:16]), 1);
        rd(R_CA, d); chk("R9", "enable cleared", 32'(d[31]), 0);
        chk("R9", "writes before error", wr_cnt, 3);
        rd(R_DA, d); chk("R9", "dst left at failed beat", d, 32'h10C);
        r0 = req_cyc;
        repeat (10) @(negedge clk);
        chk("R9", "silent after error", req_cyc, r0);
        err_en = 1'b0;
        wr(R_CB, 0);

        // R10 interrupt enables
        bench_clear();
        start(4'h0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd0);
        repeat (40) @(negedge clk);
        rd(R_CB, d); chk("R10", "done status without enable", 32'(d[18:16]), 5);
        chk("R10", "irq masked", 32'(irq), 0);
        wr(R_CB, {12'b0, 1'b0, 1'b0, 3'b001, 16'b0});
        chk("R10", "error code with error irq off", 32'(irq), 0);
        wr(R_CB, {12'b0, 1'b1, 1'b0, 3'b001, 16'b0});
        chk("R10", "error code with error irq on", 32'(irq), 1);
        wr(R_CB, 0);
        chk("R10", "status cleared", 32'(irq), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule